// File: doc/BRIEF.md
# Two-Wire Presence-Detect Memory Slave

This block models the small configuration memory that sits on a memory module and answers on a two-wire serial bus. It holds 256 bytes, loaded at reset from a parameter image. A host reads the bytes one after another, with a word pointer that advances by itself. The host may also rewrite the upper half of the array. The lower half is frozen once the module is built.

The block runs on a fast system clock. It samples the serial clock and data lines through synchronisers and finds edges, START and STOP conditions from those samples. It never drives the data line high. It only asserts a pull-low enable, which the pad turns into an open-drain output. The device address combines a fixed four-bit type code with three strap inputs, so up to eight such devices can share one bus.

The default image gives byte i the value (7·i + 3) mod 256. The one exception is byte 63, which holds the 8-bit sum of bytes 0 to 62.

Top module: `spd_eeprom`

## Requirements
- R1: After reset the slave is idle and does not pull the data line low.
- R2: The address byte is 1010, then strap[2], strap[1], strap[0], then a direction bit (0 = write, 1 = read), sent MSB first. On a match the slave acknowledges by holding the data line low for the ninth clock.
- R3: When the address byte does not match, the slave gives no acknowledge and ignores the bus until the next START.
- R4: In a write, the byte after the address sets the word pointer. Each following data byte is acknowledged and stored at the pointer.
- R5: Locations 0x00 to 0x7F are locked. A write to them is acknowledged, but the stored value does not change.
- R6: The word pointer advances by one after each byte read or written, and it wraps from 0xFF to 0x00.
- R7: Read data is sent MSB first, starting at the pointer. The slave changes the data line only while the clock line is low. Each byte the master acknowledges is followed by the next byte.
- R8: When the master does not acknowledge a read byte, the transfer ends and the slave releases the data line.
- R9: A STOP returns the slave to idle, and clock pulses after it with no START are ignored. A repeated START begins a new address phase and keeps the pointer, which allows a random read.
- R10: At reset, byte i holds (7·i + 3) mod 256 for every i other than 63. Byte 63 holds the 8-bit sum of bytes 0 to 62.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level, as seen on the wired bus |
| strap | input | 3 | Address straps; they supply the low three bits of the device address |
| sda_pull_low | output | 1 | Open-drain enable; when 1 the pad pulls the data line low |

## Verification
The byte store and the pointer advance happen on the same sampled clock fall. A two-byte write that starts at 0xFF makes that fall also wrap the pointer to 0x00, and it sends the second byte into the locked region. A read-back from 0xFF must return the new byte first and the unchanged image byte 0x03 second. The master's NACK and the slave's release also share one fall. This is checked by sampling the bus right after the NACK slot, and by a current-address read that must resume at the next pointer.

// File: rtl/spd_pkg.sv
// Shared types and the default reset image of the presence-detect slave.
// Assumes a 256-byte array; the checksum byte position is fixed.
package spd_pkg;

    localparam int SPD_DEPTH = 256;
    localparam int SUM_POS   = 63;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_WORD,
        ST_ACK_WORD,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_RACK
    } bus_state_t;

    // Builds the reset image: an affine byte pattern with a running checksum.
    function automatic logic [SPD_DEPTH*8-1:0] seed_image();
        logic [SPD_DEPTH*8-1:0] img;
        logic [7:0]             sum;
        logic [7:0]             b;
        img = '0;
        sum = '0;
        for (int i = 0; i < SPD_DEPTH; i++) begin
            b = 8'(i * 7 + 3);
            if (i == SUM_POS) b = sum;
            if (i < SUM_POS) sum = sum + b;
            img[i*8 +: 8] = b;
        end
        return img;
    endfunction

endpackage

// File: rtl/spd_line_sampler.sv
// Synchronises the serial clock and data lines to the system clock and
// flags clock edges, START and STOP. It assumes that the system clock is
// at least eight times faster than the serial clock. The idle level is high.
module spd_line_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC:0] scl_q;
    logic [SYNC:0] sda_q;
    logic          scl_prev;
    logic          sda_prev;

    // Shift both lines through the synchroniser and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[SYNC-1:0], scl_raw};
            sda_q <= {sda_q[SYNC-1:0], sda_raw};
        end
    end

    assign scl_lvl   = scl_q[SYNC-1];
    assign sda_lvl   = sda_q[SYNC-1];
    assign scl_prev  = scl_q[SYNC];
    assign sda_prev  = sda_q[SYNC];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/spd_store.sv
// Byte array with a locked lower region. It reloads the image on reset.
// A write below LOCK_LIMIT is dropped here; the bus side still acknowledges it.
module spd_store #(
    parameter int                 DEPTH      = 256,
    parameter int                 AW         = 8,
    parameter int                 LOCK_LIMIT = 128,
    parameter logic [DEPTH*8-1:0] INIT       = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam logic [AW:0] LOCK_EDGE = (AW+1)'(LOCK_LIMIT);

    logic [7:0] mem [DEPTH];

    // Reload the image on reset; store only into unlocked locations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT[i*8 +: 8];
        end else if (wr_en && ({1'b0, wr_addr} >= LOCK_EDGE)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, rd_addr} < LOCK_EDGE) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

// File: rtl/spd_bus_fsm.sv
// Bit-level slave protocol: address match, word pointer, write strobe,
// read shifting and acknowledge handling. It acts on the sampler's events.
// It assumes that only one event fires per cycle; START and STOP take priority.
module spd_bus_fsm #(
    parameter int         AW       = 8,
    parameter logic [3:0] DEV_TYPE = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    strap,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          sda_low
);
    import spd_pkg::*;

    bus_state_t state;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       rd_mode;
    logic       mack;
    logic       dev_match;
    logic       byte_done;

    assign dev_match = (shreg[7:1] == {DEV_TYPE, strap});
    assign byte_done = scl_fall && (bit_cnt == 4'd8) && !start_evt && !stop_evt;
    assign wr_en     = (state == ST_WDATA) && byte_done;
    assign wr_data   = shreg;

    // Protocol sequencer: one transition per sampled bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            rd_mode <= 1'b0;
            mack    <= 1'b0;
            sda_low <= 1'b0;
        end else if (start_evt) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            sda_low <= 1'b0;
        end else if (stop_evt) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WORD, ST_WDATA: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_DEV) begin
                            if (dev_match) begin
                                sda_low <= 1'b1;
                                rd_mode <= shreg[0];
                                state   <= ST_ACK_DEV;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WORD) begin
                            ptr     <= shreg[AW-1:0];
                            sda_low <= 1'b1;
                            state   <= ST_ACK_WORD;
                        end else begin
                            ptr     <= ptr + 1'b1;
                            sda_low <= 1'b1;
                            state   <= ST_ACK_WDATA;
                        end
                    end
                end
                ST_ACK_DEV, ST_ACK_WORD, ST_ACK_WDATA: begin
                    if (scl_fall) begin
                        if (state == ST_ACK_DEV && rd_mode) begin
                            shreg   <= rd_data;
                            sda_low <= ~rd_data[7];
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                            state   <= ST_RDATA;
                        end else begin
                            sda_low <= 1'b0;
                            state   <= (state == ST_ACK_DEV) ? ST_WORD : ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            sda_low <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_RACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_low <= ~shreg[6];
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack) begin
                            shreg   <= rd_data;
                            sda_low <= ~rd_data[7];
                            ptr     <= ptr + 1'b1;
                            state   <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    drive_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> !scl_lvl);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE && !sda_low));

    // R2
    ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_DEV) |-> (shreg[7:1] == {DEV_TYPE, strap}));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr != $past(ptr)) && ($past(state) != ST_WORD)) |-> (ptr == AW'($past(ptr) + 1'b1)));

    // R8
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && !mack && !start_evt && !stop_evt)
            |=> (!sda_low && state == ST_IDLE));

endmodule

// File: rtl/spd_eeprom.sv
// Top of the presence-detect slave: sampler, protocol engine and byte store.
// It assumes the pad turns sda_pull_low into an open-drain driver, and that
// the wired bus level comes back on sda_in.
module spd_eeprom #(
    parameter int                                   DEPTH       = spd_pkg::SPD_DEPTH,
    parameter int                                   LOCK_LIMIT  = DEPTH / 2,
    parameter logic [3:0]                           DEV_TYPE    = 4'b1010,
    parameter int                                   SYNC_STAGES = 2,
    parameter logic [spd_pkg::SPD_DEPTH*8-1:0]      INIT_IMAGE  = spd_pkg::seed_image()
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap,
    output logic       sda_pull_low
);
    localparam int AW = $clog2(DEPTH);

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic [AW-1:0] ptr;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;

    spd_line_sampler #(.SYNC(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    spd_bus_fsm #(.AW(AW), .DEV_TYPE(DEV_TYPE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_low   (sda_pull_low)
    );

    spd_store #(
        .DEPTH      (DEPTH),
        .AW         (AW),
        .LOCK_LIMIT (LOCK_LIMIT),
        .INIT       (INIT_IMAGE[DEPTH*8-1:0])
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/spd_eeprom_bench.sv
module spd_eeprom_bench;
    localparam int         Q     = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] AW_WR = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] AW_RD = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_bus;
    logic sda_pull_low;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] model [256];

    always #2 clk = ~clk;

    assign sda_bus = ~(m_low | sda_pull_low);

    spd_eeprom u_spd_eeprom (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .strap        (STRAP),
        .sda_pull_low (sda_pull_low)
    );

    function automatic logic [7:0] image_byte(input int i);
        logic [7:0] s;
        s = '0;
        if (i == 63) begin
            for (int k = 0; k < 63; k++) s = s + 8'(7 * k + 3);
            return s;
        end
        return 8'(7 * i + 3);
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; scl = 1'b1; wait_q();
        m_low = 1'b1; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        m_low = 1'b1; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        m_low = 1'b0; wait_q();
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; wait_q();
        scl = 1'b1; wait_q(); wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        b = sda_bus; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic write_bytes(input string tag, input logic [7:0] addr,
                               input logic [7:0] d0, input logic [7:0] d1, input int n);
        logic a;
        logic [7:0] p;
        bus_start();
        send_byte(AW_WR, a); check8({tag, " addr ack"}, {7'd0, a}, 8'd1);
        send_byte(addr, a);  check8({tag, " word ack"}, {7'd0, a}, 8'd1);
        p = addr;
        for (int i = 0; i < n; i++) begin
            send_byte((i == 0) ? d0 : d1, a);
            check8({tag, " data ack"}, {7'd0, a}, 8'd1);
            if (p >= 8'h80) model[p] = (i == 0) ? d0 : d1;
            p = p + 8'd1;
        end
        bus_stop();
    endtask

    task automatic read_check(input string tag, input logic [7:0] addr, input int n);
        logic a;
        logic [7:0] v;
        logic [7:0] p;
        bus_start();
        send_byte(AW_WR, a); check8({tag, " addr ack"}, {7'd0, a}, 8'd1);
        send_byte(addr, a);  check8({tag, " word ack"}, {7'd0, a}, 8'd1);
        bus_rstart();
        send_byte(AW_RD, a); check8({tag, " read ack"}, {7'd0, a}, 8'd1);
        p = addr;
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            check8({tag, " data"}, v, model[p]);
            p = p + 8'd1;
        end
        // R8: after the NACK the slave must not hold the line
        check8({tag, " R8 release"}, {7'd0, sda_pull_low}, 8'd0);
        bus_stop();
    endtask

    // R1: idle after reset
    task automatic t_reset();
        logic seen;
        seen = 1'b0;
        repeat (20) begin
            @(negedge clk);
            seen = seen | sda_pull_low;
        end
        check8("R1 idle line", {7'd0, seen}, 8'd0);
    endtask

    // R10, R7, R6: the first 64 bytes by sequential read, checksum included
    task automatic t_image();
        read_check("R10 image R7 sequential", 8'h00, 64);
        check8("R10 checksum formula", model[63], 8'h24);
    endtask

    // R4, R6: writes to the upper half land and read back in order
    task automatic t_upper_write();
        write_bytes("R4 upper write", 8'h90, 8'hA1, 8'hB2, 2);
        read_check("R4 R6 upper readback", 8'h90, 2);
        check8("R4 model byte", model[8'h91], 8'hB2);
    endtask

    // R5: locked location acknowledged but unchanged
    task automatic t_locked();
        write_bytes("R5 locked write", 8'h10, 8'hEE, 8'h00, 1);
        read_check("R5 locked readback", 8'h10, 1);
        check8("R5 image kept", model[8'h10], image_byte(16));
    endtask

    // R6: pointer wraps 0xFF -> 0x00 and the wrapped byte is locked
    task automatic t_wrap();
        write_bytes("R6 wrap write", 8'hFF, 8'h5C, 8'h77, 2);
        read_check("R6 wrap readback", 8'hFF, 2);
        check8("R6 wrapped byte", model[0], 8'h03);
    endtask

    // R3: wrong straps and wrong type code are ignored
    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte({4'b1010, 3'b011, 1'b0}, a);
        check8("R3 strap mismatch no ack", {7'd0, a}, 8'd0);
        send_byte(8'h00, a);
        check8("R3 ignored byte no ack", {7'd0, a}, 8'd0);
        bus_stop();
        bus_start();
        send_byte({4'b0010, STRAP, 1'b1}, a);
        check8("R3 type mismatch no ack", {7'd0, a}, 8'd0);
        bus_stop();
        read_check("R3 still alive", 8'h80, 1);
    endtask

    // R2, R8: current-address read continues at the next pointer
    task automatic t_current_read();
        logic a;
        logic [7:0] v;
        read_check("R2 setup", 8'h40, 1);
        bus_start();
        send_byte(AW_RD, a);
        check8("R2 read direction ack", {7'd0, a}, 8'd1);
        recv_byte(v, 1'b0);
        check8("R2 current address data", v, model[8'h41]);
        check8("R8 released after nack", {7'd0, sda_pull_low}, 8'd0);
        bus_stop();
    endtask

    // R9: clock pulses after STOP with no START get no answer
    task automatic t_stop_idle();
        logic a;
        bus_start();
        send_byte(AW_WR, a);
        check8("R9 pre-stop ack", {7'd0, a}, 8'd1);
        bus_stop();
        scl = 1'b0; wait_q();
        send_byte(AW_WR, a);
        check8("R9 no start no ack", {7'd0, a}, 8'd0);
        m_low = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        read_check("R9 repeated start read", 8'h91, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = image_byte(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_image();
        t_upper_write();
        t_locked();
        t_wrap();
        t_wrong_addr();
        t_current_read();
        t_stop_idle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule